// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit buses, called A and B, inside a larger design. Each direction of transfer has its own storage register, its own load strobe, its own source select and its own output enable. In either direction the block can forward the live value of the opposite bus, or it can forward the contents of the register that captured that bus. Each bus pin is modelled as an external value with an external-driver flag, a block drive value with a block enable, and a resolved pin value. A contention flag marks cycles in which the block and an outside driver both drive the same bus.

A register captures the resolved pin value of its own bus, whatever the selects and enables are doing. This includes a value that the block is driving onto that bus. As a result, one pair of load strobes can copy one bus into both registers. Each bus also has a keeper register. When nothing drives a bus, the keeper holds the bus at its last resolved value. If both directions pass live data and no outside driver is present, the two buses reinforce each other and hold their value.

The reset is asynchronous and active low. It clears every register and keeper, and it withdraws both block enables at once. The enables return from the first clock edge after reset is released, so the block powers up with both outputs undriven.

Top module: `regxcvr`

## Requirements
- R1: After reset, both storage registers and both keepers hold 0. With no outside driver, both a_pin and b_pin read 0x00, and both contention flags are 0.
- R2: In a cycle with ld_a high, the A register takes the a_pin value present just before the clock edge, whatever the values of sel_ab, sel_ba, oe_ab and oe_ba_n.
- R3: In a cycle with ld_b high, the B register takes the b_pin value present just before the clock edge, whatever the selects and enables.
- R4: With oe_ab=0 and oe_ba_n=1 (isolation), a_oe and b_oe are both 0, and each pin follows its own outside driver or its own keeper.
- R5: With oe_ab=1 and sel_ab=0 (live), b_oe=1 and b_out equals the current a_pin value in the same cycle.
- R6: With oe_ab=1 and sel_ab=1 (stored), b_oe=1 and b_out equals the A register.
- R7: With oe_ba_n=0 and sel_ba=0 (live), a_oe=1 and a_out equals the current b_pin value in the same cycle.
- R8: With oe_ba_n=0 and sel_ba=1 (stored), a_oe=1 and a_out equals the B register.
- R9: While one bus is driven live from the other, pulsing ld_a and ld_b together stores the source bus value in both registers.
- R10: When both selects are 1 and ld_a and ld_b are pulsed together, each register takes the pre-edge pin value. The A register receives the old B register, and the B register receives the old A register.
- R11: A bus that neither the block nor an outside driver drives holds its previous resolved value. When both directions pass live data with no outside driver, both buses show the A keeper value.
- R12: When the block enables its drive on a bus whose outside-driver flag is set, that bus's contention flag is 1 in the same cycle, and the pin takes the outside value.
- R13: While rst_n is low, a_oe and b_oe are 0 immediately, whatever the control inputs. After rst_n rises, the enables follow oe_ab and oe_ba_n from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oe_ab | input | 1 | Enables block drive onto bus B (active high) |
| oe_ba_n | input | 1 | Enables block drive onto bus A (active low) |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 A register |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 B register |
| ld_a | input | 1 | Load strobe for the A register |
| ld_b | input | 1 | Load strobe for the B register |
| a_in | input | 8 | Value of the outside driver on bus A |
| a_ext | input | 1 | Outside driver on bus A is active |
| a_out | output | 8 | Value the block drives onto bus A |
| a_oe | output | 1 | Block drives bus A |
| a_pin | output | 8 | Resolved bus A value |
| a_clash | output | 1 | Block and outside driver both on bus A |
| b_in | input | 8 | Value of the outside driver on bus B |
| b_ext | input | 1 | Outside driver on bus B is active |
| b_out | output | 8 | Value the block drives onto bus B |
| b_oe | output | 1 | Block drives bus B |
| b_pin | output | 8 | Resolved bus B value |
| b_clash | output | 1 | Block and outside driver both on bus B |

## Verification
The properties assume that inputs change only between rising edges. They also assume that reset is released away from an edge, because the keeper and capture checks compare against the pin value of the previous cycle and only hold once a full cycle has passed since reset. The stimulus drives every input on the falling edge. The sweep covers all sixteen control settings, every pattern of outside drivers and every combination of load strobes, including the simultaneous stored-mode loads whose result R10 defines. Reset is released on a falling edge, and one idle cycle follows before the enables are used.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int XW = 8;
  typedef enum logic {SRC_LIVE = 1'b0, SRC_STORED = 1'b1} src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xcvr_enable.sv
module xcvr_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_ab,
  input  logic oe_ba_n,
  output logic drv_a,
  output logic drv_b
);
  logic ready, ready_nxt;

  always_comb ready_nxt = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready <= 1'b0;
    else        ready <= ready_nxt;
  end

  always_comb begin
    drv_b = rst_n & ready & oe_ab;
    drv_a = rst_n & ready & ~oe_ba_n;
  end
endmodule

// File: rtl/xcvr_resolve.sv
module xcvr_resolve
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  input  logic         drv_a,
  input  logic         drv_b,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_b,
  input  logic [W-1:0] keep_a,
  input  logic [W-1:0] keep_b,
  output logic [W-1:0] a_res,
  output logic [W-1:0] b_res,
  output logic [W-1:0] a_val,
  output logic [W-1:0] b_val
);
  src_e src_ab, src_ba;
  logic [W-1:0] a_nolive, b_nolive;

  always_comb begin
    src_ab = src_e'(sel_ab);
    src_ba = src_e'(sel_ba);
    // Bus A as seen without any live drive coming from bus B
    if (a_ext)                             a_nolive = a_in;
    else if (drv_a && src_ba == SRC_STORED) a_nolive = reg_b;
    else                                   a_nolive = keep_a;
    // Bus B as seen without any live drive coming from bus A;
    // a mutual live loop falls back to the A keeper
    if (b_ext)      b_nolive = b_in;
    else if (drv_b) b_nolive = (src_ab == SRC_STORED) ? reg_a : keep_a;
    else            b_nolive = keep_b;

    if (a_ext)      a_res = a_in;
    else if (drv_a) a_res = (src_ba == SRC_STORED) ? reg_b : b_nolive;
    else            a_res = keep_a;

    if (b_ext)      b_res = b_in;
    else if (drv_b) b_res = (src_ab == SRC_STORED) ? reg_a : a_nolive;
    else            b_res = keep_b;

    a_val = (src_ba == SRC_STORED) ? reg_b : b_res;
    b_val = (src_ab == SRC_STORED) ? reg_a : a_res;
  end
endmodule

// File: rtl/regxcvr.sv
module regxcvr
  import xcvr_pkg::*;
#(
  parameter int W = XW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_ab,
  input  logic         oe_ba_n,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         ld_a,
  input  logic         ld_b,
  input  logic [W-1:0] a_in,
  input  logic         a_ext,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] a_pin,
  output logic         a_clash,
  input  logic [W-1:0] b_in,
  input  logic         b_ext,
  output logic [W-1:0] b_out,
  output logic         b_oe,
  output logic [W-1:0] b_pin,
  output logic         b_clash
);
  logic         drv_a, drv_b;
  logic [W-1:0] reg_a, reg_b, keep_a, keep_b;
  logic [W-1:0] a_res, b_res, a_val, b_val;

  xcvr_enable u_en (
    .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .drv_a(drv_a), .drv_b(drv_b)
  );

  xcvr_store #(.W(W)) u_rega (.clk(clk), .rst_n(rst_n), .ld(ld_a), .d(a_res), .q(reg_a));
  xcvr_store #(.W(W)) u_regb (.clk(clk), .rst_n(rst_n), .ld(ld_b), .d(b_res), .q(reg_b));
  xcvr_store #(.W(W)) u_keepa (.clk(clk), .rst_n(rst_n), .ld(1'b1), .d(a_res), .q(keep_a));
  xcvr_store #(.W(W)) u_keepb (.clk(clk), .rst_n(rst_n), .ld(1'b1), .d(b_res), .q(keep_b));

  xcvr_resolve #(.W(W)) u_res (
    .a_in(a_in), .a_ext(a_ext), .b_in(b_in), .b_ext(b_ext),
    .drv_a(drv_a), .drv_b(drv_b), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .reg_a(reg_a), .reg_b(reg_b), .keep_a(keep_a), .keep_b(keep_b),
    .a_res(a_res), .b_res(b_res), .a_val(a_val), .b_val(b_val)
  );

  always_comb begin
    a_oe    = drv_a;
    b_oe    = drv_b;
    a_out   = a_val;
    b_out   = b_val;
    a_pin   = a_res;
    b_pin   = b_res;
    a_clash = drv_a & a_ext;
    b_clash = drv_b & b_ext;
  end

  assert_cap_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> reg_a == $past(a_pin));
  assert_cap_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b |=> reg_b == $past(b_pin));
  assert_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && !sel_ab && !b_ext && a_ext) |-> b_pin == a_in);
  assert_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe && sel_ab && !b_ext) |-> b_pin == reg_a);
  assert_stored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_oe && sel_ba && !a_ext) |-> a_pin == reg_b);
  assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !a_ext && !a_oe) |-> a_pin == $past(a_pin));
  assert_clash_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ext && a_oe) |-> (a_clash && a_pin == a_in));
endmodule

// File: tb/sim_regxcvr.sv
module sim_regxcvr;
  localparam int PER = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic oe_ab, oe_ba_n, sel_ab, sel_ba, ld_a, ld_b;
  logic [7:0] a_in, b_in;
  logic a_ext, b_ext;
  logic [7:0] a_out, a_pin, b_out, b_pin;
  logic a_oe, a_clash, b_oe, b_clash;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_ra, m_rb, m_ka, m_kb, ea, eb;

  always #(PER/2) clk = ~clk;

  regxcvr u0 (
    .clk(clk), .rst_n(rst_n), .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .ld_a(ld_a), .ld_b(ld_b),
    .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_oe(a_oe), .a_pin(a_pin), .a_clash(a_clash),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_oe(b_oe), .b_pin(b_pin), .b_clash(b_clash)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic ctl(input logic oab, input logic oban, input logic sab, input logic sba);
    oe_ab = oab; oe_ba_n = oban; sel_ab = sab; sel_ba = sba;
  endtask

  // Expected pins from the requirements and the bench's own register state
  task automatic model;
    logic da, db;
    da = ~oe_ba_n; db = oe_ab;
    if (a_ext) ea = a_in;
    else if (!da) ea = m_ka;
    else if (sel_ba) ea = m_rb;
    else if (b_ext) ea = b_in;
    else if (db) ea = sel_ab ? m_ra : m_ka;
    else ea = m_kb;
    if (b_ext) eb = b_in;
    else if (!db) eb = m_kb;
    else if (sel_ab) eb = m_ra;
    else if (a_ext) eb = a_in;
    else if (da && sel_ba) eb = m_rb;
    else eb = m_ka;
  endtask

  task automatic eval;
    string ta, tb;
    #1;
    model();
    ta = a_ext ? "R12" : (oe_ba_n ? "R11" : (sel_ba ? "R8" : "R7"));
    tb = b_ext ? "R12" : (!oe_ab ? "R11" : (sel_ab ? "R6" : "R5"));
    chk("R4 a_oe", {7'd0, a_oe}, {7'd0, ~oe_ba_n});
    chk("R4 b_oe", {7'd0, b_oe}, {7'd0, oe_ab});
    chk({ta, " a_pin"}, a_pin, ea);
    chk({tb, " b_pin"}, b_pin, eb);
    chk("R12 a_clash", {7'd0, a_clash}, {7'd0, a_ext & ~oe_ba_n});
    chk("R12 b_clash", {7'd0, b_clash}, {7'd0, b_ext & oe_ab});
    if (!oe_ba_n) chk(sel_ba ? "R8 a_out" : "R7 a_out", a_out, sel_ba ? m_rb : eb);
    if (oe_ab)    chk(sel_ab ? "R6 b_out" : "R5 b_out", b_out, sel_ab ? m_ra : ea);
  endtask

  task automatic step;
    @(posedge clk);
    if (ld_a) m_ra = ea;
    if (ld_b) m_rb = eb;
    m_ka = ea; m_kb = eb;
    @(negedge clk);
  endtask

  task automatic do_reset;
    m_ra = 0; m_rb = 0; m_ka = 0; m_kb = 0;
    @(negedge clk); rst_n = 1'b1;
    ctl(0, 1, 0, 0); ld_a = 0; ld_b = 0; a_ext = 0; b_ext = 0;
    #1; model(); step();
  endtask

  initial begin
    #(PER * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ctl(1, 0, 0, 0); ld_a = 1; ld_b = 1;
    a_in = 8'h00; b_in = 8'h00; a_ext = 0; b_ext = 0;
    repeat (2) @(negedge clk);
    #1;
    // R13 enables withheld in reset even when requested; R1 zero state
    chk("R13 a_oe in reset", {7'd0, a_oe}, 8'd0);
    chk("R13 b_oe in reset", {7'd0, b_oe}, 8'd0);
    chk("R1 a_pin", a_pin, 8'h00);
    chk("R1 b_pin", b_pin, 8'h00);
    chk("R1 clash", {6'd0, a_clash, b_clash}, 8'd0);
    do_reset();

    // Near-exhaustive sweep: controls x outside drivers x load strobes
    for (int v = 0; v < 256; v++) begin
      ctl(v[0], v[1], v[2], v[3]);
      a_ext = v[4]; b_ext = v[5]; ld_a = v[6]; ld_b = v[7];
      a_in = 8'((v * 37 + 5) & 255);
      b_in = 8'((v * 91 + 200) & 255);
      eval(); step();
    end
    ld_a = 0; ld_b = 0; a_ext = 0; b_ext = 0;

    // R2 / R3: capture in isolation, read back through stored transfer
    ctl(0, 1, 1, 1); a_ext = 1; a_in = 8'h81; b_ext = 1; b_in = 8'h42;
    ld_a = 1; ld_b = 1; eval(); step();
    ld_a = 0; ld_b = 0; a_ext = 0; b_ext = 0; ctl(1, 0, 1, 1);
    eval();
    chk("R2 b_out from A reg", b_out, 8'h81);
    chk("R3 a_out from B reg", a_out, 8'h42);
    step();

    // R9: A live to B, both loads store the A value
    ctl(1, 1, 0, 0); a_ext = 1; a_in = 8'h3C; ld_a = 1; ld_b = 1; eval(); step();
    ld_a = 0; ld_b = 0; a_ext = 0; ctl(1, 0, 1, 1); eval();
    chk("R9 A reg", b_out, 8'h3C);
    chk("R9 B reg", a_out, 8'h3C);
    step();
    // R9 mirror: B live to A
    ctl(0, 0, 0, 0); b_ext = 1; b_in = 8'hC3; ld_a = 1; ld_b = 1; eval(); step();
    ld_a = 0; ld_b = 0; b_ext = 0; ctl(1, 0, 1, 1); eval();
    chk("R9 mirror A reg", b_out, 8'hC3);
    chk("R9 mirror B reg", a_out, 8'hC3);
    step();

    // R10: stored both ways with simultaneous loads swaps the registers
    ctl(0, 1, 0, 0); a_ext = 1; a_in = 8'h11; b_ext = 1; b_in = 8'h22;
    ld_a = 1; ld_b = 1; eval(); step();
    a_ext = 0; b_ext = 0; ctl(1, 0, 1, 1); eval(); step();
    ld_a = 0; ld_b = 0; eval();
    chk("R10 A reg after swap", b_out, 8'h22);
    chk("R10 B reg after swap", a_out, 8'h11);
    step();

    // R11: mutual live hold after the outside driver leaves
    ctl(1, 0, 0, 0); a_ext = 1; a_in = 8'h5A; eval(); step();
    a_ext = 0; eval(); step(); eval();
    chk("R11 A held", a_pin, 8'h5A);
    chk("R11 B held", b_pin, 8'h5A);
    step();

    // R12: contention on B
    b_ext = 1; b_in = 8'hE7; eval();
    chk("R12 b_clash set", {7'd0, b_clash}, 8'd1);
    chk("R12 b_pin outside", b_pin, 8'hE7);
    step(); b_ext = 0;

    // R13: asynchronous reset off the edge drops the enables at once
    ctl(1, 0, 0, 0); #2; rst_n = 1'b0; #1;
    chk("R13 a_oe async", {7'd0, a_oe}, 8'd0);
    chk("R13 b_oe async", {7'd0, b_oe}, 8'd0);
    chk("R1 A reg cleared", a_pin, 8'h00);
    do_reset();
    ctl(1, 0, 1, 1); eval();
    chk("R1 A reg zero after reset", b_out, 8'h00);
    step();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule